// File: doc/BRIEF.md
# Inter-Processor Mailbox with FIFO Interrupts

This block lets processors on a chip hand 32-bit messages to one another through a set of one-way mailboxes, each backed by a small message queue. A producer writes a word to a mailbox's message register to enqueue it. A consumer reads the same register to dequeue the oldest word. Per-mailbox status registers report whether a queue is full and how many words it holds, so software can poll instead of waiting for an interrupt.

Interrupts are organised by user, where a user is one interrupt destination. Every user has a status register and an enable register. Each mailbox owns two adjacent bits in them: one for "a message arrived" and one for "the queue stopped being full". Hardware sets the status bits of every user when these events occur. Software clears a status bit by writing a one to it. Each user's interrupt line is raised when any of its status bits is pending and enabled.

A small set of housekeeping registers completes the map: a fixed revision word, a control register with two idle-control bits, and a status word that shows when reset has completed. The bus is a plain 32-bit register interface with separate read and write strobes. Read data is registered.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every queue is empty, every interrupt status and enable register reads 0, and every interrupt output is low.
- R2: A read with bus_rd high at message register 0x040+4*m dequeues the oldest word of mailbox m. The word appears on bus_rdata in the cycle after the strobe and stays there until the next read. Register 0x0C0+4*m returns the number of queued words.
- R3: Register 0x080+4*m reads 1 when mailbox m holds DEPTH words and 0 otherwise. A write to a full queue without a simultaneous read is dropped, and the stored words and count stay unchanged.
- R4: A read of an empty queue returns 0, leaves its count at 0 and sets no event.
- R5: Every accepted write to mailbox m sets bit 2*m of every user's status register (0x100+8*u).
- R6: A read that takes mailbox m from full to not full sets bit 2*m+1 of every user's status register.
- R7: A write to a status register clears each bit written as 1 and leaves each bit written as 0. Other users' status registers are not affected.
- R8: The enable register of user u (0x104+8*u) reads back what was last written. irq[u] is high exactly when some bit is set in both status and enable of user u.
- R9: The control register at 0x010 keeps bits 0 and 4 as written and reads 0 in all other bits. The register at 0x014 reads 1 once reset has completed. The register at 0x000 returns the revision constant REV_ID, which is 0x00000201 by default.
- R10: When bus_rd and bus_wr are both high at a message register, the dequeue happens first and then the enqueue. On a full queue the write is accepted, the count stays DEPTH, the new-message bit is set and the not-full bit is not set. On an empty queue the read returns 0 and the count becomes 1.
- R11: Writes to the revision register, the read-only status registers or unmapped addresses change nothing, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq | output | NUM_USER | One interrupt line per user |

## Verification
Two functions can land in the same cycle: a dequeue and an enqueue on the same mailbox, when both strobes are raised together at one message register. The bench provokes this once on a queue it has filled to DEPTH and once on an empty queue. On the full queue it checks that the oldest word is returned, that the count stays at DEPTH and that only the new-message bit rises. On the empty queue it checks that the read returns 0 and the written word is the only entry left afterwards. Draining the queue in order afterwards shows that the entry written in the coincident cycle went to the correct position.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;
   localparam int ADDR_W = 12;
   localparam int BUS_W  = 32;

   localparam logic [ADDR_W-1:0] OFS_REV     = 12'h000;
   localparam logic [ADDR_W-1:0] OFS_SYSCFG  = 12'h010;
   localparam logic [ADDR_W-1:0] OFS_SYSSTAT = 12'h014;
   localparam logic [ADDR_W-1:0] OFS_MSG     = 12'h040;
   localparam logic [ADDR_W-1:0] OFS_FSTAT   = 12'h080;
   localparam logic [ADDR_W-1:0] OFS_MSTAT   = 12'h0C0;
   localparam logic [ADDR_W-1:0] OFS_ISTAT   = 12'h100;
   localparam logic [ADDR_W-1:0] OFS_IEN     = 12'h104;

   localparam logic [BUS_W-1:0] SYSCFG_MASK = 32'h0000_0011;

   function automatic logic [ADDR_W-1:0] msg_ofs(input int m);
      return OFS_MSG + ADDR_W'(4 * m);
   endfunction

   function automatic logic [ADDR_W-1:0] fstat_ofs(input int m);
      return OFS_FSTAT + ADDR_W'(4 * m);
   endfunction

   function automatic logic [ADDR_W-1:0] mstat_ofs(input int m);
      return OFS_MSTAT + ADDR_W'(4 * m);
   endfunction

   function automatic logic [ADDR_W-1:0] istat_ofs(input int u);
      return OFS_ISTAT + ADDR_W'(8 * u);
   endfunction

   function automatic logic [ADDR_W-1:0] ien_ofs(input int u);
      return OFS_IEN + ADDR_W'(8 * u);
   endfunction
endpackage

// File: rtl/ipc_mbx_queue.sv
module ipc_mbx_queue #(
   parameter int DEPTH = 4,
   parameter int DW    = 32,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          ev_new,
   output logic          ev_notfull
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic          do_push, do_pop;

   // a dequeue only acts on stored data; a coincident dequeue frees a slot
   assign do_pop  = pop && (count != '0);
   assign do_push = push && (!full || do_pop);
   assign full    = (count == CW'(DEPTH));
   assign rdata   = (count != '0) ? mem[rd_ptr] : '0;

   assign ev_new     = do_push;
   assign ev_notfull = do_pop && !do_push && full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end
endmodule

// File: rtl/ipc_mbx_irq_bank.sv
module ipc_mbx_irq_bank #(
   parameter int NB = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] set_ev,
   input  logic          clr_wr,
   input  logic          en_wr,
   input  logic [NB-1:0] wdata,
   output logic [NB-1:0] status,
   output logic [NB-1:0] enable,
   output logic          irq
);
   logic [NB-1:0] clr_mask;

   assign clr_mask = clr_wr ? wdata : '0;
   assign irq      = |(status & enable);

   // a hardware event in the same cycle as a clear keeps the bit set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         enable <= '0;
      end else begin
         status <= (status & ~clr_mask) | set_ev;
         if (en_wr) enable <= wdata;
      end
   end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
   import ipc_mbx_pkg::*;
#(
   parameter int          NUM_BOX  = 4,
   parameter int          NUM_USER = 4,
   parameter int          DEPTH    = 4,
   parameter int          DW       = 32,
   parameter logic [31:0] REV_ID   = 32'h0000_0201
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [11:0]         bus_addr,
   input  logic                bus_wr,
   input  logic [31:0]         bus_wdata,
   input  logic                bus_rd,
   output logic [31:0]         bus_rdata,
   output logic [NUM_USER-1:0] irq
);
   localparam int NB = 2 * NUM_BOX;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_chk_depth
      $error("queue depth must be a power of two, at least 2");
   end
   if (NUM_BOX < 1 || NUM_BOX > 16) begin : g_chk_box
      $error("mailbox count must be between 1 and 16");
   end
   if (NUM_USER < 1 || NUM_USER > 32) begin : g_chk_user
      $error("user count must be between 1 and 32");
   end
   if (DW < 1 || DW > BUS_W) begin : g_chk_dw
      $error("message width must fit the bus");
   end

   logic [NUM_BOX-1:0][DW-1:0] q_data;
   logic [NUM_BOX-1:0][CW-1:0] box_cnt;
   logic [NUM_BOX-1:0]         q_full;
   logic [NB-1:0]              box_ev;
   logic [NUM_USER-1:0][NB-1:0] usr_stat;
   logic [NUM_USER-1:0][NB-1:0] usr_en;
   logic [BUS_W-1:0]           cfg_q;
   logic                       rst_done;
   logic [BUS_W-1:0]           rd_mux;

   for (genvar m = 0; m < NUM_BOX; m++) begin : g_box
      logic hit, ev_new, ev_nf;
      assign hit = (bus_addr == msg_ofs(m));

      ipc_mbx_queue #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_queue (
         .clk       (clk),
         .rst_n     (rst_n),
         .push      (bus_wr && hit),
         .pop       (bus_rd && hit),
         .wdata     (bus_wdata[DW-1:0]),
         .rdata     (q_data[m]),
         .count     (box_cnt[m]),
         .full      (q_full[m]),
         .ev_new    (ev_new),
         .ev_notfull(ev_nf)
      );

      assign box_ev[2*m]   = ev_new;
      assign box_ev[2*m+1] = ev_nf;
   end

   for (genvar u = 0; u < NUM_USER; u++) begin : g_user
      ipc_mbx_irq_bank #(.NB(NB)) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .set_ev(box_ev),
         .clr_wr(bus_wr && (bus_addr == istat_ofs(u))),
         .en_wr (bus_wr && (bus_addr == ien_ofs(u))),
         .wdata (bus_wdata[NB-1:0]),
         .status(usr_stat[u]),
         .enable(usr_en[u]),
         .irq   (irq[u])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         rst_done <= 1'b0;
      end else begin
         rst_done <= 1'b1;
         if (bus_wr && bus_addr == OFS_SYSCFG) cfg_q <= bus_wdata & SYSCFG_MASK;
      end
   end

   always_comb begin
      rd_mux = '0;
      if (bus_addr == OFS_REV)     rd_mux = REV_ID;
      if (bus_addr == OFS_SYSCFG)  rd_mux = cfg_q;
      if (bus_addr == OFS_SYSSTAT) rd_mux = {{(BUS_W-1){1'b0}}, rst_done};
      for (int m = 0; m < NUM_BOX; m++) begin
         if (bus_addr == msg_ofs(m))   rd_mux = BUS_W'(q_data[m]);
         if (bus_addr == fstat_ofs(m)) rd_mux = {{(BUS_W-1){1'b0}}, q_full[m]};
         if (bus_addr == mstat_ofs(m)) rd_mux = BUS_W'(box_cnt[m]);
      end
      for (int u = 0; u < NUM_USER; u++) begin
         if (bus_addr == istat_ofs(u)) rd_mux = BUS_W'(usr_stat[u]);
         if (bus_addr == ien_ofs(u))   rd_mux = BUS_W'(usr_en[u]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/ipc_mbx_checker.sv
module ipc_mbx_checker
   import ipc_mbx_pkg::*;
#(
   parameter int NUM_BOX  = 4,
   parameter int NUM_USER = 4,
   parameter int DEPTH    = 4,
   parameter int NB       = 2 * NUM_BOX,
   parameter int CW       = $clog2(DEPTH + 1)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [11:0]                 bus_addr,
   input logic                        bus_wr,
   input logic                        bus_rd,
   input logic [31:0]                 bus_rdata,
   input logic [NUM_USER-1:0]         irq,
   input logic [NUM_BOX-1:0][CW-1:0]  box_cnt,
   input logic [NUM_USER-1:0][NB-1:0] usr_stat,
   input logic [NUM_USER-1:0][NB-1:0] usr_en,
   input logic [NB-1:0]               stat_wdata
);
   p_rst_quiet_r1: assert property (@(posedge clk) !rst_n |=> (irq == '0));

   for (genvar m = 0; m < NUM_BOX; m++) begin : g_box
      p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && !bus_rd && bus_addr == msg_ofs(m) && box_cnt[m] == CW'(DEPTH))
         |=> (box_cnt[m] == CW'(DEPTH)));

      p_empty_pop_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && !bus_wr && bus_addr == msg_ofs(m) && box_cnt[m] == '0)
         |=> (bus_rdata == '0 && box_cnt[m] == '0));

      for (genvar u = 0; u < NUM_USER; u++) begin : g_user
         p_new_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == msg_ofs(m) && box_cnt[m] != CW'(DEPTH))
            |=> usr_stat[u][2*m]);

         p_notfull_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && !bus_wr && bus_addr == msg_ofs(m) && box_cnt[m] == CW'(DEPTH))
            |=> usr_stat[u][2*m+1]);
      end
   end

   for (genvar u = 0; u < NUM_USER; u++) begin : g_usr
      p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == istat_ofs(u))
         |=> ((usr_stat[u] & $past(stat_wdata)) == '0));

      p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (usr_en[u] == '0) |-> !irq[u]);
   end
endmodule

bind ipc_mailbox ipc_mbx_checker #(
   .NUM_BOX (NUM_BOX),
   .NUM_USER(NUM_USER),
   .DEPTH   (DEPTH),
   .NB      (NB),
   .CW      (CW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .box_cnt   (box_cnt),
   .usr_stat  (usr_stat),
   .usr_en    (usr_en),
   .stat_wdata(bus_wdata[NB-1:0])
);

// File: tb/ipc_mailbox_bench.sv
`timescale 1ns/1ps
module ipc_mailbox_bench;
   localparam int NUSR = 4;
   localparam logic [31:0] REV = 32'h0000_0201;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NUSR-1:0] irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   ipc_mailbox u_ipc_mailbox (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
   );

   function automatic logic [11:0] a_msg(int m);  return 12'(12'h040 + 4*m); endfunction
   function automatic logic [11:0] a_fst(int m);  return 12'(12'h080 + 4*m); endfunction
   function automatic logic [11:0] a_mst(int m);  return 12'(12'h0C0 + 4*m); endfunction
   function automatic logic [11:0] a_ist(int u);  return 12'(12'h100 + 8*u); endfunction
   function automatic logic [11:0] a_ien(int u);  return 12'(12'h104 + 8*u); endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic rdwr(input logic [11:0] a, input logic [31:0] wd, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = wd; bus_rd = 1'b1; bus_wr = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b0;
      d = bus_rdata;
   endtask

   task automatic expect_rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      check(tag, d, exp);
   endtask

   task automatic clear_all();
      for (int u = 0; u < NUSR; u++) wr(a_ist(u), 32'hFF);
   endtask

   task automatic t_reset();
      check("R1 irq after reset", 32'(irq), 32'h0);
      for (int m = 0; m < 4; m++) begin
         expect_rd("R1 msg count", a_mst(m), 32'h0);
         expect_rd("R1 full flag", a_fst(m), 32'h0);
      end
      for (int u = 0; u < NUSR; u++) begin
         expect_rd("R1 status", a_ist(u), 32'h0);
         expect_rd("R1 enable", a_ien(u), 32'h0);
      end
   endtask

   task automatic t_config();
      expect_rd("R9 revision", 12'h000, REV);
      expect_rd("R9 sysstatus", 12'h014, 32'h1);
      expect_rd("R9 sysconfig reset", 12'h010, 32'h0);
      wr(12'h010, 32'hFFFF_FFFF);
      expect_rd("R9 sysconfig mask", 12'h010, 32'h11);
      wr(12'h010, 32'h10);
      expect_rd("R9 sysconfig rmw", 12'h010, 32'h10);
   endtask

   task automatic t_order();
      clear_all();
      wr(a_msg(1), 32'hA1); wr(a_msg(1), 32'hA2); wr(a_msg(1), 32'hA3);
      expect_rd("R2 count 3", a_mst(1), 32'd3);
      for (int u = 0; u < NUSR; u++) expect_rd("R5 new bit all users", a_ist(u), 32'h04);
      expect_rd("R2 first", a_msg(1), 32'hA1);
      expect_rd("R2 second", a_msg(1), 32'hA2);
      expect_rd("R2 third", a_msg(1), 32'hA3);
      expect_rd("R2 drained", a_mst(1), 32'd0);
   endtask

   task automatic t_full();
      clear_all();
      for (int i = 0; i < 4; i++) wr(a_msg(2), 32'hB0 + 32'(i));
      expect_rd("R3 full flag", a_fst(2), 32'h1);
      wr(a_msg(2), 32'hB4);
      expect_rd("R3 count after dropped push", a_mst(2), 32'd4);
      clear_all();
      expect_rd("R3 oldest kept", a_msg(2), 32'hB0);
      expect_rd("R3 full flag clears", a_fst(2), 32'h0);
      expect_rd("R6 not-full user0", a_ist(0), 32'h20);
      expect_rd("R6 not-full user3", a_ist(3), 32'h20);
      expect_rd("R3 order 1", a_msg(2), 32'hB1);
      expect_rd("R3 order 2", a_msg(2), 32'hB2);
      expect_rd("R3 order 3, dropped word absent", a_msg(2), 32'hB3);
      expect_rd("R3 empty", a_mst(2), 32'd0);
   endtask

   task automatic t_empty();
      clear_all();
      expect_rd("R4 empty read", a_msg(3), 32'h0);
      expect_rd("R4 count stays", a_mst(3), 32'h0);
      expect_rd("R4 no event", a_ist(0), 32'h0);
   endtask

   task automatic t_w1c_irq();
      clear_all();
      check("R8 irq idle", 32'(irq), 32'h0);
      wr(a_msg(0), 32'h55);
      expect_rd("R5 user1 status", a_ist(1), 32'h01);
      check("R8 irq masked", 32'(irq), 32'h0);
      wr(a_ien(1), 32'h01);
      expect_rd("R8 enable readback", a_ien(1), 32'h01);
      check("R8 irq user1", 32'(irq), 32'b0010);
      wr(a_ist(1), 32'h00);
      expect_rd("R7 write 0 keeps", a_ist(1), 32'h01);
      wr(a_ist(1), 32'hFE);
      expect_rd("R7 other ones keep bit0", a_ist(1), 32'h01);
      wr(a_ist(1), 32'h01);
      expect_rd("R7 write 1 clears", a_ist(1), 32'h00);
      expect_rd("R7 other user untouched", a_ist(2), 32'h01);
      check("R8 irq drops", 32'(irq), 32'h0);
      wr(a_ien(1), 32'h00);
      expect_rd("R2 drain", a_msg(0), 32'h55);
   endtask

   task automatic t_coincide();
      logic [31:0] d;
      clear_all();
      for (int i = 0; i < 4; i++) wr(a_msg(0), 32'hC0 + 32'(i));
      clear_all();
      rdwr(a_msg(0), 32'hC4, d);
      check("R10 full coincide read", d, 32'hC0);
      expect_rd("R10 count stays full", a_mst(0), 32'd4);
      expect_rd("R10 only new bit", a_ist(0), 32'h01);
      for (int i = 1; i < 5; i++) expect_rd("R10 order after coincide", a_msg(0), 32'hC0 + 32'(i));
      expect_rd("R10 drained", a_mst(0), 32'd0);
      rdwr(a_msg(0), 32'hD0, d);
      check("R10 empty coincide read", d, 32'h0);
      expect_rd("R10 count one", a_mst(0), 32'd1);
      expect_rd("R10 stored word", a_msg(0), 32'hD0);
   endtask

   task automatic t_unmapped();
      wr(12'h0FC, 32'hDEAD_BEEF);
      expect_rd("R11 unmapped reads 0", 12'h0FC, 32'h0);
      wr(12'h000, 32'hFFFF_FFFF);
      expect_rd("R11 revision fixed", 12'h000, REV);
      wr(12'h014, 32'h0);
      expect_rd("R11 sysstatus fixed", 12'h014, 32'h1);
      expect_rd("R11 gap reads 0", 12'h020, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_config();
      t_order();
      t_full();
      t_empty();
      t_w1c_irq();
      t_coincide();
      t_unmapped();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule